// File: doc/BRIEF.md
# Dual-Width Host Bus Register Port

This block is the slave side of a host processor bus. Through it a host reaches a bank of twenty-four 16-bit internal registers. One set of pins serves four bus styles: a 16-bit or an 8-bit data path, each with either a separate address bus or address and data shared on the same pins. Two bits of the configuration register (index 10) choose the style at run time. After reset the block is in 16-bit separate-bus mode.

Every host address is eight bits wide. Bits [7:6] carry an execution-condition code, bits [5:1] give the register index and bit [0] picks a byte. The block packs 8-bit transfers into 16-bit registers with the high byte first. On reads it drives its output lanes with per-lane enables and leaves them released at all other times. Each data phase also sends an access notice to the core with the index, the condition code and the direction. Register 12 is a read-only status word. It shows four event flags from the core, their four mask bits and a combined interrupt bit.

The bus control state machine has four states. `ST_IDLE` waits for an access. `ST_ADDR_OK` means a multiplexed address is latched and the block is waiting for a strobe. `ST_XFER_RD` and `ST_XFER_WR` hold a read or write data phase until its strobe is released. The transitions are:
- latch: `ST_IDLE`/`ST_ADDR_OK` → `ST_ADDR_OK` while the latch strobe is high in multiplexed mode.
- open read: `ST_IDLE` (separate mode) or `ST_ADDR_OK` → `ST_XFER_RD` on a read strobe.
- open write: `ST_IDLE` (separate mode) or `ST_ADDR_OK` → `ST_XFER_WR` on a write strobe. The register is written on this transition.
- close: `ST_XFER_*` → `ST_IDLE` when the strobe drops or chip select is released.
- abort: `ST_ADDR_OK` → `ST_IDLE` when chip select is released.

Top module: `hbr_host_if`

## Requirements
- R1: After reset, every stored register reads 0x0000, the mode is 16-bit separate-bus, `host_doe` is 0 and `acc_valid` is 0.
- R2: In 16-bit mode a write stores the whole word at index addr[5:1] and a read returns it on all lanes (`host_doe`=2'b11). Address bit 0 is ignored.
- R3: In 8-bit mode only `host_din[7:0]`/`host_dout[7:0]` are used and `host_doe`=2'b01. Address bit 0 = 0 reaches bits [15:8] of the register, and bit 0 = 1 reaches bits [7:0].
- R4: In multiplexed mode the address is taken from `host_din[7:0]` while chip select is low and `host_ale` is high. In the following data phase `host_strb_n`=0 means read and `host_rw`=0 means write. In separate mode `host_strb_n`=0 opens the data phase and `host_rw` (1 read, 0 write) gives the direction.
- R5: Bit 0 of register 10 selects the 8-bit path and bit 1 selects multiplexed mode. A new value applies from the next access. Those bits change only when register 10 is written.
- R6: Register 12 reads as flags in bits [3:0], masks in bits [7:4] and the interrupt bit in bit 15, with the other bits 0. Writes to it have no effect.
- R7: `irq` is 1 exactly when some flag and its mask bit are both 1.
- R8: An index of 24 or more reads 0x0000, and a write to it changes no register.
- R9: `host_doe` is non-zero only while chip select is low and a read strobe is active. In multiplexed mode an address must also have been latched.
- R10: Each data phase gives a single-cycle `acc_valid` with `acc_write`, `acc_idx` = addr[5:1] and `acc_cond` = addr[7:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs_n | input | 1 | Chip select, active low |
| host_ale | input | 1 | Address latch strobe (multiplexed mode) |
| host_strb_n | input | 1 | Data strobe (separate mode) or read strobe (multiplexed mode), active low |
| host_rw | input | 1 | Direction, 1 for read (separate mode), or write strobe, active low (multiplexed mode) |
| host_addr | input | 8 | Address pins in separate mode |
| host_din | input | 16 | Data in, carrying the address during the latch phase in multiplexed mode |
| host_dout | output | 16 | Read data |
| host_doe | output | 2 | Output enable per byte lane |
| ev_flags | input | 4 | Event flags from the core |
| ev_masks | input | 4 | Mask bits paired with the flags |
| irq | output | 1 | Interrupt request |
| acc_valid | output | 1 | Single-cycle access notice |
| acc_write | output | 1 | Notice is for a write |
| acc_idx | output | 5 | Register index of the access |
| acc_cond | output | 2 | Execution-condition code of the access |

## Verification
Read data and `host_doe` are combinational from the pins and the latched address. The bench samples them one time unit after the falling edge on which the strobe is applied. A write and the latching of a multiplexed address take effect on the first rising edge that sees the strobe. Any readback or mode change is therefore checked only in a later access. `acc_valid` and its fields are registered on that same rising edge and are checked at the next falling edge. At the falling edge after that, `acc_valid` must be 0 again.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
    localparam int IDX_W          = 5;
    localparam int COND_W         = 2;
    localparam int CFG_NARROW_BIT = 0;
    localparam int CFG_MUX_BIT    = 1;

    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic [IDX_W-1:0]  idx;
        logic              lsb;
    } hbr_addr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR_OK,
        ST_XFER_RD,
        ST_XFER_WR
    } hbr_state_e;
endpackage

// File: rtl/hbr_bus_fsm.sv
module hbr_bus_fsm
    import hbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              strb_n,
    input  logic              rw,
    input  logic              muxed,
    input  logic [7:0]        addr_pins,
    input  logic [7:0]        din_lo,
    output hbr_addr_t         eff_addr,
    output logic              wr_fire,
    output logic              rd_active,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [COND_W-1:0] acc_cond
);
    hbr_state_e state, nxt;
    hbr_addr_t  lat_addr;
    logic       sel, rd_req, wr_req, fire_rd;

    assign sel    = !cs_n;
    assign rd_req = muxed ? !strb_n : (!strb_n && rw);
    assign wr_req = muxed ? !rw     : (!strb_n && !rw);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sel) begin
                    if (muxed) begin
                        if (ale) nxt = ST_ADDR_OK;
                    end else if (rd_req) begin
                        nxt = ST_XFER_RD;
                    end else if (wr_req) begin
                        nxt = ST_XFER_WR;
                    end
                end
            end
            ST_ADDR_OK: begin
                if (!sel)        nxt = ST_IDLE;
                else if (ale)    nxt = ST_ADDR_OK;
                else if (rd_req) nxt = ST_XFER_RD;
                else if (wr_req) nxt = ST_XFER_WR;
            end
            ST_XFER_RD: if (!sel || !rd_req) nxt = ST_IDLE;
            ST_XFER_WR: if (!sel || !wr_req) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_addr <= '0;
        end else begin
            state <= nxt;
            if (muxed && sel && ale && (state == ST_IDLE || state == ST_ADDR_OK))
                lat_addr <= din_lo;
        end
    end

    always_comb begin
        eff_addr  = muxed ? lat_addr : hbr_addr_t'(addr_pins);
        wr_fire   = (nxt == ST_XFER_WR) && (state != ST_XFER_WR);
        fire_rd   = (nxt == ST_XFER_RD) && (state != ST_XFER_RD);
        rd_active = sel && rd_req &&
                    (!muxed || state == ST_ADDR_OK || state == ST_XFER_RD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_write <= 1'b0;
            acc_idx   <= '0;
            acc_cond  <= '0;
        end else begin
            acc_valid <= wr_fire || fire_rd;
            if (wr_fire || fire_rd) begin
                acc_write <= wr_fire;
                acc_idx   <= eff_addr.idx;
                acc_cond  <= eff_addr.cond;
            end
        end
    end

    // R10: the access notice lasts exactly one cycle
    p_single_notice_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid);
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
    import hbr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 24,
    parameter int CFG_IDX  = 10,
    parameter int STAT_IDX = 12,
    parameter int NUM_EV   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              narrow,
    input  hbr_addr_t         addr,
    input  logic [DATA_W-1:0] din,
    input  logic [NUM_EV-1:0] ev_flags,
    input  logic [NUM_EV-1:0] ev_masks,
    output logic [DATA_W-1:0] rd_word,
    output logic              cfg_narrow,
    output logic              cfg_muxed,
    output logic              irq
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0]          words [NUM_REGS];
    logic [NUM_REGS*DATA_W-1:0] stored_flat;
    logic [DATA_W-1:0]          stat_word;

    assign irq = |(ev_flags & ev_masks);

    always_comb begin
        stat_word                     = '0;
        stat_word[NUM_EV-1:0]         = ev_flags;
        stat_word[2*NUM_EV-1:NUM_EV]  = ev_masks;
        stat_word[DATA_W-1]           = irq;
    end

    generate
        for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            if (gi == STAT_IDX) begin : g_stat
                assign words[gi] = stat_word;
                assign stored_flat[gi*DATA_W +: DATA_W] = '0;
            end else begin : g_rw
                logic [DATA_W-1:0] q;
                logic              hit;
                assign hit = wr_fire && (addr.idx == IDX_W'(gi));
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        q <= '0;
                    else if (hit) begin
                        if (!narrow)
                            q <= din;
                        else if (addr.lsb)
                            q[HALF-1:0] <= din[HALF-1:0];
                        else
                            q[DATA_W-1:HALF] <= din[HALF-1:0];
                    end
                end
                assign words[gi] = q;
                assign stored_flat[gi*DATA_W +: DATA_W] = q;
            end
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr.idx == IDX_W'(i)) rd_word = words[i];
    end

    assign cfg_narrow = words[CFG_IDX][CFG_NARROW_BIT];
    assign cfg_muxed  = words[CFG_IDX][CFG_MUX_BIT];

    // R5: mode bits move only on a write to the configuration register
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && addr.idx == IDX_W'(CFG_IDX)) |=> $stable({cfg_narrow, cfg_muxed}));

    // R8: writes beyond the bank leave all storage untouched
    p_oob_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && int'(addr.idx) >= NUM_REGS) |=> $stable(stored_flat));

    // R7: an interrupt cannot start without an enabled mask
    p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ev_masks != '0));
endmodule

// File: rtl/hbr_host_if.sv
module hbr_host_if
    import hbr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 24,
    parameter int CFG_IDX  = 10,
    parameter int STAT_IDX = 12,
    parameter int NUM_EV   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_ale,
    input  logic              host_strb_n,
    input  logic              host_rw,
    input  logic [7:0]        host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic [DATA_W/8-1:0] host_doe,
    input  logic [NUM_EV-1:0] ev_flags,
    input  logic [NUM_EV-1:0] ev_masks,
    output logic              irq,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [COND_W-1:0] acc_cond
);
    localparam int LANES = DATA_W / 8;
    localparam int HALF  = DATA_W / 2;

    hbr_addr_t         eff_addr;
    logic              wr_fire, rd_active, cfg_narrow, cfg_muxed;
    logic [DATA_W-1:0] rd_word;

    hbr_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (host_cs_n),
        .ale       (host_ale),
        .strb_n    (host_strb_n),
        .rw        (host_rw),
        .muxed     (cfg_muxed),
        .addr_pins (host_addr),
        .din_lo    (host_din[7:0]),
        .eff_addr  (eff_addr),
        .wr_fire   (wr_fire),
        .rd_active (rd_active),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_idx   (acc_idx),
        .acc_cond  (acc_cond)
    );

    hbr_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .CFG_IDX  (CFG_IDX),
        .STAT_IDX (STAT_IDX),
        .NUM_EV   (NUM_EV)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .narrow     (cfg_narrow),
        .addr       (eff_addr),
        .din        (host_din),
        .ev_flags   (ev_flags),
        .ev_masks   (ev_masks),
        .rd_word    (rd_word),
        .cfg_narrow (cfg_narrow),
        .cfg_muxed  (cfg_muxed),
        .irq        (irq)
    );

    always_comb begin
        if (cfg_narrow) begin
            host_dout           = '0;
            host_dout[HALF-1:0] = eff_addr.lsb ? rd_word[HALF-1:0] : rd_word[DATA_W-1:HALF];
            host_doe            = rd_active ? LANES'(1) : '0;
        end else begin
            host_dout = rd_word;
            host_doe  = rd_active ? {LANES{1'b1}} : '0;
        end
    end

    // R9: lanes stay released whenever the chip is not selected
    p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n |-> (host_doe == '0));
endmodule

// File: tb/hbr_host_if_bench.sv
module hbr_host_if_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1, host_ale = 1'b0, host_strb_n = 1'b1, host_rw = 1'b1;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic [1:0]  host_doe;
    logic [3:0]  ev_flags = '0, ev_masks = '0;
    logic        irq, acc_valid, acc_write;
    logic [4:0]  acc_idx;
    logic [1:0]  acc_cond;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    hbr_host_if u_hbr_host_if (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_ale(host_ale),
        .host_strb_n(host_strb_n), .host_rw(host_rw), .host_addr(host_addr),
        .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
        .ev_flags(ev_flags), .ev_masks(ev_masks), .irq(irq),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx), .acc_cond(acc_cond)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sep_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_din = d; host_rw = 1'b0; host_strb_n = 1'b0; host_cs_n = 1'b0;
        @(negedge clk);
        host_strb_n = 1'b1; host_rw = 1'b1; host_cs_n = 1'b1;
    endtask

    task automatic sep_read(input logic [7:0] a, output logic [15:0] d, output logic [1:0] oe);
        @(negedge clk);
        host_addr = a; host_rw = 1'b1; host_strb_n = 1'b0; host_cs_n = 1'b0;
        #1; d = host_dout; oe = host_doe;
        @(negedge clk);
        host_strb_n = 1'b1; host_cs_n = 1'b1;
    endtask

    task automatic mux_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        host_cs_n = 1'b0; host_ale = 1'b1; host_din = {8'h00, a};
        @(negedge clk);
        host_ale = 1'b0; host_din = d; host_rw = 1'b0;
        @(negedge clk);
        host_rw = 1'b1; host_cs_n = 1'b1;
    endtask

    task automatic mux_read(input logic [7:0] a, output logic [15:0] d, output logic [1:0] oe,
                            output logic [1:0] oe_addr_phase);
        @(negedge clk);
        host_cs_n = 1'b0; host_ale = 1'b1; host_din = {8'h00, a};
        @(negedge clk);
        host_ale = 1'b0; host_din = '0;
        #1; oe_addr_phase = host_doe;
        host_strb_n = 1'b0;
        #1; d = host_dout; oe = host_doe;
        @(negedge clk);
        host_strb_n = 1'b1; host_cs_n = 1'b1;
    endtask

    task automatic t_reset;
        logic [15:0] d; logic [1:0] oe;
        chk("R1 doe after reset", {14'd0, host_doe}, 16'h0000);
        chk("R1 acc_valid after reset", {15'd0, acc_valid}, 16'h0000);
        sep_read(8'h02, d, oe);
        chk("R1 reg1 reset value", d, 16'h0000);
        chk("R1 16-bit default lanes", {14'd0, oe}, 16'h0003);
        sep_read(8'h14, d, oe);
        chk("R1 config reset value", d, 16'h0000);
    endtask

    task automatic t_word;
        logic [15:0] d; logic [1:0] oe;
        sep_write(8'h07, 16'hBEEF);
        sep_read(8'h06, d, oe);
        chk("R2 word readback, lsb ignored", d, 16'hBEEF);
        chk("R2 both lanes driven", {14'd0, oe}, 16'h0003);
        sep_write(8'h2E, 16'h1234);
        sep_read(8'h2F, d, oe);
        chk("R2 top index readback", d, 16'h1234);
    endtask

    task automatic t_notice;
        @(negedge clk);
        host_addr = 8'hC6; host_din = 16'h0F0F; host_rw = 1'b0; host_strb_n = 1'b0; host_cs_n = 1'b0;
        @(negedge clk);
        chk("R10 valid after write edge", {15'd0, acc_valid}, 16'h0001);
        chk("R10 write flag", {15'd0, acc_write}, 16'h0001);
        chk("R10 index", {11'd0, acc_idx}, 16'h0003);
        chk("R10 condition", {14'd0, acc_cond}, 16'h0003);
        chk("R9 no drive during write", {14'd0, host_doe}, 16'h0000);
        @(negedge clk);
        chk("R10 valid lasts one cycle", {15'd0, acc_valid}, 16'h0000);
        host_strb_n = 1'b1; host_rw = 1'b1; host_cs_n = 1'b1;
        @(negedge clk);
        host_addr = 8'h46; host_strb_n = 1'b0; host_cs_n = 1'b0;
        @(negedge clk);
        chk("R10 read notice", {14'd0, acc_valid, acc_write}, 16'h0002);
        chk("R10 read condition", {14'd0, acc_cond}, 16'h0001);
        host_strb_n = 1'b1; host_cs_n = 1'b1;
    endtask

    task automatic t_oob;
        logic [15:0] d; logic [1:0] oe;
        sep_write(8'h30, 16'hFFFF);
        sep_write(8'h3E, 16'hAAAA);
        sep_read(8'h30, d, oe);
        chk("R8 index 24 reads zero", d, 16'h0000);
        sep_read(8'h3E, d, oe);
        chk("R8 index 31 reads zero", d, 16'h0000);
        sep_read(8'h2E, d, oe);
        chk("R8 reg23 untouched", d, 16'h1234);
        sep_read(8'h06, d, oe);
        chk("R8 reg3 untouched", d, 16'h0F0F);
    endtask

    task automatic t_status;
        logic [15:0] d; logic [1:0] oe;
        @(negedge clk);
        ev_flags = 4'b0101; ev_masks = 4'b0100;
        #1; chk("R7 irq with matched mask", {15'd0, irq}, 16'h0001);
        sep_read(8'h18, d, oe);
        chk("R6 status layout", d, 16'h8045);
        sep_write(8'h18, 16'hFFFF);
        sep_read(8'h18, d, oe);
        chk("R6 status write ignored", d, 16'h8045);
        @(negedge clk);
        ev_masks = 4'b1010;
        #1; chk("R7 irq off with disjoint mask", {15'd0, irq}, 16'h0000);
        sep_read(8'h18, d, oe);
        chk("R6 status without irq", d, 16'h00A5);
        @(negedge clk);
        ev_flags = 4'b0000; ev_masks = 4'b1111;
        #1; chk("R7 irq off without flags", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_quiet;
        @(negedge clk);
        host_cs_n = 1'b1; host_strb_n = 1'b0; host_rw = 1'b1;
        #1; chk("R9 deselected read strobe", {14'd0, host_doe}, 16'h0000);
        host_cs_n = 1'b0; host_strb_n = 1'b1;
        #1; chk("R9 selected without strobe", {14'd0, host_doe}, 16'h0000);
        host_cs_n = 1'b1;
    endtask

    task automatic t_narrow;
        logic [15:0] d; logic [1:0] oe;
        sep_write(8'h14, 16'h0001);
        sep_write(8'h08, 16'hFFAB);
        sep_write(8'h09, 16'hEECD);
        sep_read(8'h08, d, oe);
        chk("R3 high byte on low lane", d, 16'h00AB);
        chk("R3 one lane driven", {14'd0, oe}, 16'h0001);
        sep_read(8'h09, d, oe);
        chk("R3 low byte", d, 16'h00CD);
        sep_write(8'h15, 16'h0000);
        sep_read(8'h08, d, oe);
        chk("R5 back to 16-bit, packed word", d, 16'hABCD);
    endtask

    task automatic t_mux16;
        logic [15:0] d; logic [1:0] oe, oe_a;
        sep_write(8'h14, 16'h0002);
        mux_write(8'h0A, 16'h5A5A);
        mux_read(8'h0A, d, oe, oe_a);
        chk("R4 muxed word readback", d, 16'h5A5A);
        chk("R4 muxed lanes", {14'd0, oe}, 16'h0003);
        chk("R9 no drive in address phase", {14'd0, oe_a}, 16'h0000);
        host_addr = 8'h2E;
        mux_read(8'h06, d, oe, oe_a);
        chk("R4 address from data pins", d, 16'h0F0F);
    endtask

    task automatic t_mux8;
        logic [15:0] d; logic [1:0] oe, oe_a;
        mux_write(8'h14, 16'h0003);
        mux_write(8'h0C, 16'h0011);
        mux_write(8'h0D, 16'h0022);
        mux_read(8'h0C, d, oe, oe_a);
        chk("R3 muxed narrow high byte", d, 16'h0011);
        chk("R3 muxed narrow lane", {14'd0, oe}, 16'h0001);
        mux_write(8'h15, 16'h0000);
        sep_read(8'h0C, d, oe);
        chk("R5 separate 16-bit after clear", d, 16'h1122);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_notice();
        t_oob();
        t_status();
        t_quiet();
        t_narrow();
        t_mux16();
        t_mux8();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule